// File: doc/BRIEF.md
# Carrying Subtract Execute Stage

This block is the execute stage for one fixed-point register-to-register instruction: subtract with carry out. Each cycle it receives a 32-bit instruction word and the two operand values that the register file has already read for it. It checks the opcode fields. On a match it forms RB minus RA as the one's complement of RA plus RB plus one. One clock later it presents the difference together with the target register index and a write-enable pulse.

The block holds the architectural carry (CA), overflow (OV) and sticky summary-overflow (SO) flags, and a 4-bit condition field. Two bits of the instruction decide which of these change. The carry is written on every matching instruction. OV and SO change only when the overflow-enable bit is set. The condition field is recorded only when the record bit is set. A separate flag-write port lets surrounding logic load CA, OV and SO directly, and this port is the only way to clear SO apart from reset.

A two-state write-back machine tracks the output stage. ST_IDLE means no result is being presented. ST_WRITE means a result is on the write port. A matching valid instruction moves either state to ST_WRITE (hit). Any other cycle moves either state to ST_IDLE (miss).

Top module: `subc_exec`

## Requirements
- R1: Bits are numbered with bit 0 as the MSB of `instr`. The word matches only when bits 0-5 (`instr[31:26]`) equal 31 and bits 22-30 (`instr[9:1]`) equal 8. A non-matching word causes no write and leaves CA, OV, SO and the condition field unchanged.
- R2: After a matching word is accepted with `in_valid` high, the following cycle shows `wr_en`=1, `wr_data` = (~RA + RB + 1) mod 2^32, and `wr_idx` = bits 6-10 (`instr[25:21]`). `wr_en` is 0 in any cycle that does not follow an accepted instruction.
- R3: Every accepted instruction writes CA with the carry out of the 32-bit sum ~RA + RB + 1. CA=1 means no borrow, that is RB >= RA unsigned.
- R4: When bit 21 (`instr[10]`, overflow enable) is 1, OV is written with the signed overflow of RB - RA, and SO becomes SO OR OV.
- R5: When the overflow-enable bit is 0, OV and SO keep their values.
- R6: When bit 31 (`instr[0]`, record) is 1, `cond` is written as {LT, GT, EQ, SO}, with LT in `cond[3]` and SO in `cond[0]`. Exactly one of LT, GT or EQ is set, from the signed result compared with zero. The SO copy is the value SO holds after the same clock edge. When the record bit is 0, `cond` is unchanged.
- R7: SO is sticky. Once it is set, no instruction clears it. Only reset or the flag-write port can clear it.
- R8: When `flag_wr_en` is high, CA, OV and SO take `flag_wr_ca`, `flag_wr_ov` and `flag_wr_so` on the next edge, overriding any update from an instruction in the same cycle.
- R9: Synchronous reset clears CA, OV, SO, `cond` and `wr_en`.
- R10: A matching word presented with `in_valid` low is ignored, exactly as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are valid |
| instr | input | 32 | Instruction word (bit 0 = MSB) |
| opa | input | 32 | Value of source register RA |
| opb | input | 32 | Value of source register RB |
| flag_wr_en | input | 1 | Load the flags directly |
| flag_wr_ca | input | 1 | Carry value to load |
| flag_wr_ov | input | 1 | Overflow value to load |
| flag_wr_so | input | 1 | Summary-overflow value to load |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 5 | Target register index |
| wr_data | output | 32 | Difference RB - RA |
| ca | output | 1 | Carry flag |
| ov | output | 1 | Overflow flag |
| so | output | 1 | Sticky summary-overflow flag |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench uses directed scenarios aimed at the places where a subtract unit is easily wrong. The first is the carry sense. A design that reports a borrow instead of a carry would flip CA on the no-borrow cases. The second is the overflow rule. A design that tests the signs of the wrong operands would miss the overflow from a most-negative RA, or would report one when the sign change is harmless. The scenarios also check that the overflow-enable bit guards both OV and SO, and that the record bit guards the condition field. A design that updated these flags on every instruction would show changed flags after the forms that must leave them alone. Finally, the bench checks that the condition field copies the SO value from after the update, which a stale copy would miss. It checks that SO survives a later overflow-free instruction, that the flag-write port wins a same-cycle collision, and that words with a wrong opcode, a wrong extended opcode or a low valid raise no write.

// File: rtl/subc_pkg.sv
package subc_pkg;

    localparam int INSTR_W  = 32;
    localparam int IDX_W    = 5;
    localparam int PRIM_W   = 6;
    localparam int EXT_W    = 9;

    localparam logic [PRIM_W-1:0] PRIM_CODE = 6'd31;
    localparam logic [EXT_W-1:0]  EXT_CODE  = 9'd8;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] rt;
        logic             oe;
        logic             rc;
    } dec_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wb_state_e;

endpackage

// File: rtl/subc_decode.sv
module subc_decode
    import subc_pkg::*;
(
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic [PRIM_W-1:0] prim_f;
    logic [EXT_W-1:0]  ext_f;

    always_comb begin
        prim_f  = instr[INSTR_W-1 -: PRIM_W];
        ext_f   = instr[EXT_W:1];
        dec.hit = in_valid && (prim_f == PRIM_CODE) && (ext_f == EXT_CODE);
        dec.rt  = instr[INSTR_W-1-PRIM_W -: IDX_W];
        dec.oe  = instr[EXT_W+1];
        dec.rc  = instr[0];
    end

endmodule

// File: rtl/subc_alu.sv
module subc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = {1'b0, ~a} + {1'b0, b} + SUM_W'(1);
        res   = sum[W-1:0];
        carry = sum[W];
        ovf   = (a[W-1] != b[W-1]) && (res[W-1] != b[W-1]);
    end

endmodule

// File: rtl/subc_flags.sv
module subc_flags #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic         oe,
    input  logic         rc,
    input  logic [W-1:0] res,
    input  logic         carry,
    input  logic         ovf,
    input  logic         fw_en,
    input  logic         fw_ca,
    input  logic         fw_ov,
    input  logic         fw_so,
    output logic         ca,
    output logic         ov,
    output logic         so,
    output logic [3:0]   cond
);

    logic       ca_n, ov_n, so_n;
    logic [3:0] cond_n;
    logic       lt, gt, eq;

    always_comb begin
        lt = res[W-1];
        eq = (res == '0);
        gt = !lt && !eq;

        ca_n = ca;
        ov_n = ov;
        so_n = so;
        if (upd) begin
            ca_n = carry;
            if (oe) begin
                ov_n = ovf;
                so_n = so | ovf;
            end
        end
        if (fw_en) begin
            ca_n = fw_ca;
            ov_n = fw_ov;
            so_n = fw_so;
        end

        cond_n = cond;
        if (upd && rc) begin
            cond_n = {lt, gt, eq, so_n};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ca   <= 1'b0;
            ov   <= 1'b0;
            so   <= 1'b0;
            cond <= 4'b0000;
        end else begin
            ca   <= ca_n;
            ov   <= ov_n;
            so   <= so_n;
            cond <= cond_n;
        end
    end

    AST_OV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(upd && oe) && !fw_en) |=> $stable(ov) && $stable(so)); // R5
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (so && !fw_en) |=> so); // R7
    AST_OV_FEEDS_SO: assert property (@(posedge clk) disable iff (rst)
        (upd && oe && !fw_en) |=> (!ov || so)); // R4
    AST_COND_ONE_REL: assert property (@(posedge clk) disable iff (rst)
        (upd && rc) |=> ($countones(cond[3:1]) == 1) && (cond[0] == so)); // R6
    AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(upd && rc) |=> $stable(cond)); // R6
    AST_FW_LOAD: assert property (@(posedge clk) disable iff (rst)
        fw_en |=> (ca == $past(fw_ca)) && (ov == $past(fw_ov)) && (so == $past(fw_so))); // R8

endmodule

// File: rtl/subc_exec.sv
module subc_exec
    import subc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [W-1:0]       opa,
    input  logic [W-1:0]       opb,
    input  logic               flag_wr_en,
    input  logic               flag_wr_ca,
    input  logic               flag_wr_ov,
    input  logic               flag_wr_so,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [W-1:0]       wr_data,
    output logic               ca,
    output logic               ov,
    output logic               so,
    output logic [3:0]         cond
);

    dec_t       dec;
    logic [W-1:0] alu_res;
    logic       alu_carry;
    logic       alu_ovf;
    wb_state_e  state_q, state_n;

    subc_decode u_decode (
        .in_valid (in_valid),
        .instr    (instr),
        .dec      (dec)
    );

    subc_alu #(.W(W)) u_alu (
        .a     (opa),
        .b     (opb),
        .res   (alu_res),
        .carry (alu_carry),
        .ovf   (alu_ovf)
    );

    subc_flags #(.W(W)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .upd   (dec.hit),
        .oe    (dec.oe),
        .rc    (dec.rc),
        .res   (alu_res),
        .carry (alu_carry),
        .ovf   (alu_ovf),
        .fw_en (flag_wr_en),
        .fw_ca (flag_wr_ca),
        .fw_ov (flag_wr_ov),
        .fw_so (flag_wr_so),
        .ca    (ca),
        .ov    (ov),
        .so    (so),
        .cond  (cond)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  state_n = dec.hit ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_n = dec.hit ? ST_WRITE : ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx  <= '0;
            wr_data <= '0;
        end else if (dec.hit) begin
            wr_idx  <= dec.rt;
            wr_data <= alu_res;
        end
    end

    always_comb begin
        wr_en = (state_q == ST_WRITE);
    end

    AST_WE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        dec.hit |=> wr_en && (wr_idx == $past(dec.rt))); // R2
    AST_WE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |=> !wr_en); // R1
    AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !flag_wr_en) |=> !wr_en && $stable(ca) && $stable(cond)); // R10

endmodule

// File: tb/subc_exec_bench.sv
module subc_exec_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        flag_wr_en = 1'b0;
    logic        flag_wr_ca = 1'b0;
    logic        flag_wr_ov = 1'b0;
    logic        flag_wr_so = 1'b0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic        ca, ov, so;
    logic [3:0]  cond;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    subc_exec u_subc_exec (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opa(opa), .opb(opb),
        .flag_wr_en(flag_wr_en), .flag_wr_ca(flag_wr_ca),
        .flag_wr_ov(flag_wr_ov), .flag_wr_so(flag_wr_so),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ca(ca), .ov(ov), .so(so), .cond(cond)
    );

    function automatic logic [31:0] mk(input logic [5:0] prim, input logic [4:0] rt,
                                       input logic oe, input logic [8:0] ext, input logic rc);
        return {prim, rt, 5'd4, 5'd10, oe, ext, rc};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] ra,
                         input logic [31:0] rb, input logic v);
        @(negedge clk);
        in_valid = v; instr = w; opa = ra; opb = rb;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 wr_en", {31'b0, wr_en}, 32'd0);
        chk("R9 flags", {29'b0, ca, ov, so}, 32'd0);
        chk("R9 cond", {28'b0, cond}, 32'd0);
    endtask

    task automatic t_basic;
        issue(mk(6'd31, 5'd6, 1'b0, 9'd8, 1'b0), 32'h80007000, 32'h90003000, 1'b1);
        chk("R2 wr_en", {31'b0, wr_en}, 32'd1);
        chk("R2 wr_data", wr_data, 32'h0FFFC000);
        chk("R2 wr_idx", {27'b0, wr_idx}, 32'd6);
        chk("R3 ca", {31'b0, ca}, 32'd1);
        chk("R5 ov/so", {30'b0, ov, so}, 32'd0);
        chk("R6 cond unchanged", {28'b0, cond}, 32'd0);
        @(negedge clk);
        chk("R2 wr_en pulse", {31'b0, wr_en}, 32'd0);
    endtask

    task automatic t_record_lt;
        issue(mk(6'd31, 5'd7, 1'b0, 9'd8, 1'b1), 32'h00004500, 32'h80007000, 1'b1);
        chk("R2 data", wr_data, 32'h80002B00);
        chk("R6 LT", {28'b0, cond}, 32'b1000);
        chk("R3 ca", {31'b0, ca}, 32'd1);
    endtask

    task automatic t_overflow;
        issue(mk(6'd31, 5'd6, 1'b1, 9'd8, 1'b0), 32'h80000000, 32'h00004500, 1'b1);
        chk("R2 data", wr_data, 32'h80004500);
        chk("R4 ov/so", {30'b0, ov, so}, 32'b11);
        chk("R3 ca", {31'b0, ca}, 32'd0);
        chk("R6 cond held", {28'b0, cond}, 32'b1000);
    endtask

    task automatic t_sticky;
        issue(mk(6'd31, 5'd1, 1'b1, 9'd8, 1'b1), 32'h1, 32'h1, 1'b1);
        chk("R4 ov cleared", {31'b0, ov}, 32'd0);
        chk("R7 so sticky", {31'b0, so}, 32'd1);
        chk("R6 EQ+SO", {28'b0, cond}, 32'b0011);
    endtask

    task automatic t_oe_off;
        issue(mk(6'd31, 5'd2, 1'b0, 9'd8, 1'b1), 32'h80000000, 32'h0, 1'b1);
        chk("R5 ov held", {31'b0, ov}, 32'd0);
        chk("R3 ca borrow", {31'b0, ca}, 32'd0);
        chk("R6 LT+SO", {28'b0, cond}, 32'b1001);
        issue(mk(6'd31, 5'd3, 1'b0, 9'd8, 1'b1), 32'h1, 32'h5, 1'b1);
        chk("R2 data", wr_data, 32'h4);
        chk("R6 GT+SO", {28'b0, cond}, 32'b0101);
    endtask

    task automatic t_ignored;
        issue(mk(6'd30, 5'd9, 1'b1, 9'd8, 1'b1), 32'h80000000, 32'h1, 1'b1);
        chk("R1 bad prim", {27'b0, wr_en, ca, ov, so, 1'b0}, {27'b0, 5'b01010});
        chk("R1 cond", {28'b0, cond}, 32'b0101);
        issue(mk(6'd31, 5'd9, 1'b1, 9'd40, 1'b1), 32'h80000000, 32'h1, 1'b1);
        chk("R1 bad ext", {27'b0, wr_en, ca, ov, so, 1'b0}, {27'b0, 5'b01010});
        chk("R1 cond", {28'b0, cond}, 32'b0101);
        issue(mk(6'd31, 5'd9, 1'b1, 9'd8, 1'b1), 32'h80000000, 32'h1, 1'b0);
        chk("R10 invalid", {27'b0, wr_en, ca, ov, so, 1'b0}, {27'b0, 5'b01010});
        chk("R10 cond", {28'b0, cond}, 32'b0101);
    endtask

    task automatic t_flag_port;
        @(negedge clk);
        flag_wr_en = 1'b1; flag_wr_ca = 1'b1; flag_wr_ov = 1'b0; flag_wr_so = 1'b0;
        @(negedge clk);
        flag_wr_en = 1'b0;
        chk("R8 load", {29'b0, ca, ov, so}, 32'b100);
        chk("R7 so cleared", {31'b0, so}, 32'd0);
        @(negedge clk);
        flag_wr_en = 1'b1; flag_wr_ca = 1'b0; flag_wr_ov = 1'b0; flag_wr_so = 1'b0;
        in_valid = 1'b1; instr = mk(6'd31, 5'd12, 1'b1, 9'd8, 1'b1);
        opa = 32'h80000000; opb = 32'h1;
        @(negedge clk);
        flag_wr_en = 1'b0; in_valid = 1'b0;
        chk("R8 priority", {29'b0, ca, ov, so}, 32'd0);
        chk("R2 data", wr_data, 32'h80000001);
        chk("R6 cond", {28'b0, cond}, 32'b1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_record_lt();
        t_overflow();
        t_sticky();
        t_oe_off();
        t_ignored();
        t_flag_port();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule